// File: doc/BRIEF.md
# Memory Controller Application-Port Model

This block is a synthesizable stand-in for the application side of a DRAM controller. User logic can be built and checked against it without a vendor core. Commands arrive on a command channel guarded by an enable/ready handshake. Write data arrives on its own channel, which has its own ready signal. Write data is held in a FIFO, so a data word may be presented well ahead of its command, in the same cycle, or shortly after it.

Write commands wait in a small queue until a data word is available. The two are then paired in arrival order and committed to an internal word array. A read samples the array in the cycle it is accepted. The word comes back after a fixed latency, marked by a data-valid strobe, and reads return in the order they were issued. After reset a calibration-done flag rises after a fixed delay. A pseudo-random stall on command ready can be switched on to exercise the user's backpressure handling. Two sticky flags report protocol misuse: data that lags its write command too long, and command codes that are not defined.

Top module: `memui_model`

## Requirements
- R1: While reset is held, and in the first cycle after it, cal_done, cmd_rdy, wd_rdy, rd_valid, proto_err and bad_op are all 0.
- R2: cal_done rises exactly CAL_CYCLES (16) clock edges after reset is released and then stays high. While cal_done is low, cmd_rdy and wd_rdy are both low, so no command or data word is taken.
- R3: A command is accepted only at a clock edge where cmd_en and cmd_rdy are both high. cmd_op 3'b000 is a write and cmd_op 3'b001 is a read.
- R4: Every accepted read produces exactly one rd_valid strobe, carrying the word, RD_LAT (8) cycles after the cycle in which the read was accepted. Read results come back in issue order.
- R5: The word index is cmd_addr shifted right by 3, taken modulo DEPTH (256). Addresses that differ only in bits [2:0], or that differ by a multiple of DEPTH*8, reach the same word.
- R6: A data word enters the 16-entry write-data FIFO at an edge where wd_wren and wd_rdy are both high. wd_rdy is low while 16 words are held, and a word offered then is not taken.
- R7: A write is committed when the command queue and the data FIFO both hold an entry. Commands and data words are paired in arrival order. A read accepted after the commit returns the new word.
- R8: proto_err stays 0 when each write's data word arrives any number of cycles before its command, in the same cycle, or one or two cycles after it.
- R9: When a write's data word arrives three or more cycles after the command was accepted, proto_err becomes 1 and stays 1 until reset.
- R10: A command with any cmd_op other than 3'b000 or 3'b001 is consumed by the handshake. It changes no memory word, produces no rd_valid strobe, and sets the sticky bad_op flag.
- R11: Once calibration is done, cmd_rdy is also driven low when the command queue is full and, with BP_EN set, in cycles picked by a free-running LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | output | 1 | Calibration-complete flag |
| cmd_en | input | 1 | Command valid |
| cmd_op | input | 3 | Command code: 000 write, 001 read |
| cmd_addr | input | ADDR_W (28) | Byte-style address; word index is addr>>3 |
| cmd_rdy | output | 1 | Command ready |
| wd_wren | input | 1 | Write-data valid |
| wd_data | input | DATA_W (128) | Write-data word |
| wd_rdy | output | 1 | Write-data ready (FIFO not full) |
| rd_valid | output | 1 | Read-data strobe |
| rd_data | output | DATA_W (128) | Read-data word |
| proto_err | output | 1 | Sticky: write data arrived too late |
| bad_op | output | 1 | Sticky: undefined command code seen |

## Verification
The embedded assertions check the following on every cycle:
- no command or data is offered ready before calibration;
- the calibration flag and both error flags never fall outside reset;
- neither FIFO is pushed when full or popped when empty;
- no read strobe appears without a read in flight.

The bench scenarios are needed for the rest:
- exact read latency and issue order;
- the address-to-word mapping and wrap;
- in-order pairing of commands with early, same-cycle or late data;
- the two-cycle lag limit;
- the refusal of a seventeenth data word;
- the fact that undefined commands leave memory untouched.

// File: rtl/memui_pkg.sv
package memui_pkg;

  typedef enum logic [2:0] {
    OP_WR = 3'b000,
    OP_RD = 3'b001
  } memui_op_e;

  localparam logic [7:0] LFSR_SEED = 8'hA5;

  // 8-bit maximal-length Fibonacci step (x^8 + x^6 + x^5 + x^4 + 1)
  function automatic logic [7:0] lfsr_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/memui_fifo.sv
module memui_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] slot_q [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = slot_q[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wp[AW-1:0]] <= din;
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("fifo pushed while full");
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("fifo popped while empty");

endmodule

// File: rtl/memui_rdpipe.sv
module memui_rdpipe #(
  parameter int W   = 8,
  parameter int LAT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   dat_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vld_q[0] <= 1'b0;
        else     vld_q[0] <= in_vld;
        dat_q[0] <= in_dat;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) vld_q[g] <= 1'b0;
        else     vld_q[g] <= vld_q[g-1];
        dat_q[g] <= dat_q[g-1];
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_dat = dat_q[LAT-1];

endmodule

// File: rtl/memui_model.sv
module memui_model
  import memui_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int DATA_W     = 128,
  parameter int DEPTH      = 256,
  parameter int WDF_DEPTH  = 16,
  parameter int CMDQ_DEPTH = 4,
  parameter int RD_LAT     = 8,
  parameter int CAL_CYCLES = 16,
  parameter bit BP_EN      = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cal_done,
  input  logic              cmd_en,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rdy,
  input  logic              wd_wren,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_rdy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              proto_err,
  output logic              bad_op
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);
  localparam int SLK_W = $clog2(WDF_DEPTH + CMDQ_DEPTH + 4) + 1;
  localparam int OUT_W = $clog2(RD_LAT + 2);

  function automatic logic [IDX_W-1:0] word_idx(input logic [ADDR_W-1:0] a);
    return IDX_W'((a >> 3) % ADDR_W'(DEPTH));
  endfunction

  // ---------------- calibration delay
  logic [CAL_W-1:0] cal_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_cnt  <= '0;
      cal_done <= 1'b0;
    end else if (!cal_done) begin
      cal_cnt  <= cal_cnt + 1'b1;
      cal_done <= (cal_cnt == CAL_W'(CAL_CYCLES - 1));
    end
  end

  // ---------------- optional pseudo-random stall
  logic bp;
  if (BP_EN) begin : g_bp
    logic [7:0] lfsr;
    always_ff @(posedge clk) begin
      if (rst) lfsr <= LFSR_SEED;
      else     lfsr <= lfsr_step(lfsr);
    end
    assign bp = lfsr[0] & lfsr[2];
  end else begin : g_nobp
    assign bp = 1'b0;
  end

  // ---------------- handshake events (named for assertions)
  logic cq_empty, cq_full, wf_empty, wf_full;
  logic [IDX_W-1:0]  acc_idx, cq_idx;
  logic [DATA_W-1:0] wf_dout;
  logic cmd_acc, wr_acc, rd_acc, bad_acc, wd_push, commit;

  assign cmd_rdy = cal_done & ~bp & ~cq_full;
  assign wd_rdy  = cal_done & ~wf_full;
  assign cmd_acc = cmd_en & cmd_rdy;
  assign wr_acc  = cmd_acc & (cmd_op == OP_WR);
  assign rd_acc  = cmd_acc & (cmd_op == OP_RD);
  assign bad_acc = cmd_acc & (cmd_op != OP_WR) & (cmd_op != OP_RD);
  assign wd_push = wd_wren & wd_rdy;
  assign commit  = ~cq_empty & ~wf_empty;
  assign acc_idx = word_idx(cmd_addr);

  memui_fifo #(.W(IDX_W), .DEPTH(CMDQ_DEPTH)) u_cmdq (
    .clk(clk), .rst(rst), .push(wr_acc), .din(acc_idx), .pop(commit),
    .dout(cq_idx), .empty(cq_empty), .full(cq_full)
  );

  memui_fifo #(.W(DATA_W), .DEPTH(WDF_DEPTH)) u_wdf (
    .clk(clk), .rst(rst), .push(wd_push), .din(wd_data), .pop(commit),
    .dout(wf_dout), .empty(wf_empty), .full(wf_full)
  );

  // ---------------- word array
  logic [DATA_W-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (commit) mem[cq_idx] <= wf_dout;
  end

  memui_rdpipe #(.W(DATA_W), .LAT(RD_LAT)) u_rdp (
    .clk(clk), .rst(rst), .in_vld(rd_acc), .in_dat(mem[acc_idx]),
    .out_vld(rd_valid), .out_dat(rd_data)
  );

  // ---------------- data-lag monitor
  // slack = words pushed so far minus writes accepted at least two cycles ago
  logic             acc_d1, acc_d2;
  logic [SLK_W-1:0] slack, slack_nx;
  logic             lag_breach;
  assign slack_nx   = slack + SLK_W'(wd_push) - SLK_W'(acc_d2);
  assign lag_breach = slack_nx[SLK_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_d1    <= 1'b0;
      acc_d2    <= 1'b0;
      slack     <= '0;
      proto_err <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      acc_d1 <= wr_acc;
      acc_d2 <= acc_d1;
      slack  <= slack_nx;
      if (lag_breach) proto_err <= 1'b1;
      if (bad_acc)    bad_op    <= 1'b1;
    end
  end

  // ---------------- assertions
  logic [OUT_W-1:0] rd_inflight;
  always_ff @(posedge clk) begin
    if (rst) rd_inflight <= '0;
    else     rd_inflight <= rd_inflight + OUT_W'(rd_acc) - OUT_W'(rd_valid);
  end

  p_quiet_before_cal_r2: assert property (@(posedge clk) disable iff (rst)
    !cal_done |-> (!cmd_rdy && !wd_rdy)) else $error("ready before calibration");
  p_cal_holds_r2: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> cal_done) else $error("cal_done fell");
  p_rsp_has_req_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_inflight != '0)) else $error("read strobe without request");
  p_lag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err) else $error("proto_err cleared");
  p_bad_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    bad_op |=> bad_op) else $error("bad_op cleared");

endmodule

// File: tb/sim_memui_model.sv
`timescale 1ns/1ps
module sim_memui_model;
  localparam int AW = 28, DW = 128, DEPTH = 256, LAT = 8, CAL = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cal_done, cmd_en, cmd_rdy, wd_wren, wd_rdy, rd_valid, proto_err, bad_op;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_data, rd_data;

  memui_model u0 (
    .clk(clk), .rst(rst), .cal_done(cal_done), .cmd_en(cmd_en), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_rdy(cmd_rdy), .wd_wren(wd_wren), .wd_data(wd_data),
    .wd_rdy(wd_rdy), .rd_valid(rd_valid), .rd_data(rd_data),
    .proto_err(proto_err), .bad_op(bad_op)
  );

  int checks = 0, errors = 0, cyc = 0, nrsp = 0, stalls = 0;
  logic [DW-1:0] rsp_data [128];
  int            rsp_cyc  [128];
  logic [DW-1:0] mdl [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (!rst && rd_valid && nrsp < 128) begin
      rsp_data[nrsp] = rd_data;
      rsp_cyc[nrsp]  = cyc;
      nrsp++;
    end
    if (!rst && cal_done && !cmd_rdy) stalls++;
  end

  // kind 0 write (data first), kind 1 read; {kind[3:0], addr[11:0], seed[31:0]}
  localparam logic [47:0] VEC [9] = '{
    {4'h0, 12'h010, 32'h1111_0001},
    {4'h0, 12'h018, 32'h2222_0002},
    {4'h0, 12'h7F8, 32'h3333_0003},
    {4'h1, 12'h010, 32'h0},
    {4'h1, 12'h017, 32'h0},
    {4'h1, 12'h7F8, 32'h0},
    {4'h0, 12'h010, 32'h4444_0004},
    {4'h1, 12'h013, 32'h0},
    {4'h1, 12'h810, 32'h0}
  };

  function automatic logic [DW-1:0] pat(input logic [31:0] s);
    return {s, ~s, s ^ 32'h5A5A_5A5A, s + 32'd1};
  endfunction
  function automatic int midx(input logic [AW-1:0] a);
    return int'((a >> 3) % DEPTH);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_data(input logic [DW-1:0] d);
    bit r;
    wd_data = d; wd_wren = 1'b1;
    forever begin
      r = wd_rdy;
      @(posedge clk); @(negedge clk);
      if (r) break;
    end
    wd_wren = 1'b0;
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] a, output int acc);
    bit r;
    cmd_op = op; cmd_addr = a; cmd_en = 1'b1;
    forever begin
      r = cmd_rdy; acc = cyc + 1;
      @(posedge clk); @(negedge clk);
      if (r) break;
    end
    cmd_en = 1'b0;
  endtask

  task automatic send_both(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit rc, rw, cd = 0, wdn = 0;
    cmd_op = 3'b000; cmd_addr = a; cmd_en = 1'b1; wd_data = d; wd_wren = 1'b1;
    while (!(cd && wdn)) begin
      rc = cmd_rdy && !cd; rw = wd_rdy && !wdn;
      @(posedge clk); @(negedge clk);
      if (rc) begin cd = 1; cmd_en = 1'b0; end
      if (rw) begin wdn = 1; wd_wren = 1'b0; end
    end
  endtask

  // mode 0: data leads, 1: same cycle, 2/3: data lags by that many cycles
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
    int acc;
    if (mode == 0) begin push_data(d); send_cmd(3'b000, a, acc); end
    else if (mode == 1) send_both(a, d);
    else begin
      send_cmd(3'b000, a, acc);
      repeat (mode - 1) @(negedge clk);
      push_data(d);
    end
    mdl[midx(a)] = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    int acc, n0;
    n0 = nrsp;
    send_cmd(3'b001, a, acc);
    for (int i = 0; i < 30 && nrsp == n0; i++) @(negedge clk);
    chk(nrsp > n0, "R4 read strobe seen", DW'(nrsp - n0), DW'(1));
    if (nrsp > n0) begin
      chk(rsp_data[n0] == mdl[midx(a)], req, rsp_data[n0], mdl[midx(a)]);
      // valid in cycle RD_LAT after acceptance -> edge stamp differs by LAT-1
      chk(rsp_cyc[n0] - acc == LAT - 1, "R4 latency", DW'(rsp_cyc[n0] - acc), DW'(LAT - 1));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_en = 1'b0; wd_wren = 1'b0; cmd_op = '0; cmd_addr = '0; wd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cal_done, cmd_rdy, wd_rdy, rd_valid, proto_err, bad_op} == 6'b0, "R1 reset outputs",
        DW'({cal_done, cmd_rdy, wd_rdy, rd_valid, proto_err, bad_op}), DW'(0));
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc, n0;
    do_reset();
    @(negedge clk);
    chk({cal_done, cmd_rdy, wd_rdy, rd_valid} == 4'b0, "R1 first cycle after reset",
        DW'({cal_done, cmd_rdy, wd_rdy, rd_valid}), DW'(0));
    repeat (CAL - 2) @(negedge clk);   // negedge after edge 15
    chk(!cal_done && !cmd_rdy && !wd_rdy, "R2 not ready at edge 15", DW'(cal_done), DW'(0));
    @(negedge clk);                    // after edge 16
    chk(cal_done === 1'b1, "R2 cal_done at edge 16", DW'(cal_done), DW'(1));

    // table walk: R3 R5 R7
    foreach (VEC[i]) begin
      if (VEC[i][47:44] == 4'h0)
        do_write(AW'(VEC[i][43:32]), pat(VEC[i][31:0]), 0);
      else
        do_read(AW'(VEC[i][43:32]), "R5 R7 table read");
    end

    // same-cycle and lagging data (R8)
    do_write(AW'('h040), pat(32'hA0), 1);
    do_write(AW'('h048), pat(32'hA1), 2);
    do_read(AW'('h040), "R8 same-cycle data");
    do_read(AW'('h048), "R8 lag-2 data");
    chk(proto_err == 1'b0, "R8 no proto_err", DW'(proto_err), DW'(0));

    // order of back-to-back reads (R4)
    n0 = nrsp;
    send_cmd(3'b001, AW'('h040), acc);
    send_cmd(3'b001, AW'('h018), acc);
    repeat (LAT + 6) @(negedge clk);
    chk(nrsp == n0 + 2, "R4 one strobe per read", DW'(nrsp - n0), DW'(2));
    chk(rsp_data[n0] == mdl[8] && rsp_data[n0+1] == mdl[3], "R4 order",
        rsp_data[n0], mdl[8]);

    // undefined command (R10)
    n0 = nrsp;
    send_cmd(3'b101, AW'('h040), acc);
    repeat (LAT + 4) @(negedge clk);
    chk(nrsp == n0, "R10 no strobe", DW'(nrsp - n0), DW'(0));
    chk(bad_op == 1'b1, "R10 bad_op set", DW'(bad_op), DW'(1));
    do_read(AW'('h040), "R10 memory unchanged");

    // FIFO fill (R6)
    for (int i = 0; i < 16; i++) push_data(pat(32'd500 + 32'(i)));
    chk(wd_rdy == 1'b0, "R6 wd_rdy low when full", DW'(wd_rdy), DW'(0));
    wd_data = pat(32'd999); wd_wren = 1'b1;
    repeat (2) @(negedge clk);
    wd_wren = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send_cmd(3'b000, AW'('h100 + 8 * i), acc);
      mdl[midx(AW'('h100 + 8 * i))] = pat(32'd500 + 32'(i));
    end
    repeat (4) @(negedge clk);
    do_write(AW'('h300), pat(32'd77), 1);
    do_read(AW'('h300), "R6 extra word refused");
    do_read(AW'('h100), "R7 pairing order first");
    do_read(AW'('h178), "R7 pairing order last");

    chk(stalls > 0, "R11 backpressure seen", DW'(stalls), DW'(1));

    // late data (R9)
    do_reset();
    repeat (CAL + 1) @(negedge clk);
    do_write(AW'('h020), pat(32'hBB), 3);
    chk(proto_err == 1'b1, "R9 proto_err set", DW'(proto_err), DW'(1));
    repeat (5) @(negedge clk);
    chk(proto_err == 1'b1, "R9 proto_err sticky", DW'(proto_err), DW'(1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule